// File: doc/BRIEF.md
# Dual-Channel Metering Tone Output Formatter

This block sits behind two metering-tone detectors. Each detector raises a tone-valid flag while its measurement logic currently judges the line tone correct. The block turns each flag into a clean channel output in one of two formats. In tone follower format the output is a level that tracks a confirmed decode. In packet format the output changes only after enough tone (or enough silence) has built up inside a bounded observation window. A shared format select and a shared output release act on both channels at once. All timing is counted in milliseconds, taken from a tick prescaler on the system clock.

The tick prescaler divides the system clock by alternating terms of `TICK_BASE` and `TICK_BASE+1` cycles. With the default of 3579 this gives a close approximation of 1 ms from a 3.579545 MHz clock. Each channel runs two state machines at all times, so changing the format takes effect at once and needs no re-settling.

The follower machine has two states, `TF_OFF` and `TF_ON`. The only transitions are `TF_OFF->TF_ON` and `TF_ON->TF_OFF`. Each is taken after `TF_RUN_MS` consecutive disagreeing samples.

The packet machine has four states: `PK_WAIT_OFF`, `PK_RISE_WIN`, `PK_ON` and `PK_FALL_WIN`. Its transitions are:
- open-rise `PK_WAIT_OFF->PK_RISE_WIN` on a tone sample;
- respond `PK_RISE_WIN->PK_ON` when the tone count reaches the threshold;
- rise-expire `PK_RISE_WIN->PK_WAIT_OFF` when the window closes first;
- open-fall `PK_ON->PK_FALL_WIN` on a no-tone sample;
- de-respond `PK_FALL_WIN->PK_WAIT_OFF` when the no-tone count reaches the threshold;
- fall-expire `PK_FALL_WIN->PK_ON` when the window closes first.

Each tri-state channel pin is modelled as a data bit plus an active-high drive enable.

Top module: `metering_out_ctrl`

## Requirements
- R1: While `rst_n` is low, every channel state machine is off, so `ch_data` is all zero and `ch_drive` equals the inverse of `out_release`.
- R2: `out_release`=1 forces every `ch_drive` bit and every `ch_data` bit to 0. `out_release`=0 sets every `ch_drive` bit to 1. Both take effect in the same cycle, with no clock edge needed.
- R3: Millisecond ticks fall on the `TICK_BASE`-th rising edge after reset is released. After that, the gaps between ticks alternate `TICK_BASE+1`, `TICK_BASE`, `TICK_BASE+1`, and so on.
- R4: `out_sel`=1 routes the follower level to `ch_data`; `out_sel`=0 routes the packet level. The switch takes effect in the same cycle, and both machines keep running whichever format is selected.
- R5: In follower format, a channel output changes after `TF_RUN_MS` consecutive tick samples that differ from it. Any agreeing sample restarts the count.
- R6: In packet format with the output at 0, the first tone sample opens a window of `WIN_MS` samples. The output goes to 1 on the clock edge of the sample that brings the window's tone count to `THRESH_MS`.
- R7: If a packet window reaches `WIN_MS` samples without the count reaching `THRESH_MS`, the window closes and the output keeps its value. The next disagreeing sample opens a fresh window.
- R8: In packet format with the output at 1, the first no-tone sample opens a window. The output returns to 0 on the clock edge of the sample that brings the no-tone count to `THRESH_MS`.
- R9: The channels are independent: one channel's `tone_valid` bit never affects another channel's output.
- R10: `tone_valid` is sampled only on tick cycles. Its value between ticks has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_valid | input | NUM_CH | Per-channel tone-valid flag from the measurement logic |
| out_sel | input | 1 | Format select: 1 = tone follower, 0 = packet |
| out_release | input | 1 | 1 releases every channel pin (high impedance) |
| ch_data | output | NUM_CH | Per-channel output data bit |
| ch_drive | output | NUM_CH | Per-channel active-high drive enable |

## Verification
A follower run counter that is off by one would move an output edge by exactly one tick interval. A packet window that is too long or too short would turn an expected respond into a rise-expire, or the reverse. In both cases the error shows on `ch_data` within one tick of the faulty sample. A prescaler that loses the alternation would drift the output edges by one cycle per pair of ticks, so every later edge lands late or early. The cycle reference in the bench therefore catches it well before the packet thresholds are reached. Swapped select or release decoding shows up in the same cycle.

// File: rtl/metering_pkg.sv
package metering_pkg;

    typedef enum logic {
        TF_OFF,
        TF_ON
    } tf_state_t;

    typedef enum logic [1:0] {
        PK_WAIT_OFF,
        PK_RISE_WIN,
        PK_ON,
        PK_FALL_WIN
    } pk_state_t;

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int unsigned TICK_BASE = 3579
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(TICK_BASE + 1);

    logic [CW-1:0] cnt_q;
    logic          long_q;
    logic [CW-1:0] limit;

    // Short term of TICK_BASE cycles, then a long term of TICK_BASE+1 cycles.
    assign limit = long_q ? CW'(TICK_BASE) : CW'(TICK_BASE - 1);
    assign tick  = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            long_q <= ~long_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tone_follower.sv
module tone_follower
    import metering_pkg::*;
#(
    parameter int unsigned RUN_MS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sample,
    output logic level
);
    localparam int unsigned RW = $clog2(RUN_MS + 1);

    tf_state_t     st_q, st_d;
    logic [RW-1:0] run_q, run_d;

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (tick) begin
            if (sample != (st_q == TF_ON)) begin
                if (run_q == RW'(RUN_MS - 1)) begin
                    run_d = '0;
                    unique case (st_q)
                        TF_OFF:  st_d = TF_ON;
                        TF_ON:   st_d = TF_OFF;
                        default: st_d = TF_OFF;
                    endcase
                end else begin
                    run_d = run_q + 1'b1;
                end
            end else begin
                run_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TF_OFF;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    always_comb begin
        level = (st_q == TF_ON);
    end
endmodule

// File: rtl/packet_integrator.sv
module packet_integrator
    import metering_pkg::*;
#(
    parameter int unsigned WIN_MS    = 44,
    parameter int unsigned THRESH_MS = 32   // must be 2..WIN_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sample,
    output logic level
);
    localparam int unsigned CW = $clog2(WIN_MS + 1);

    pk_state_t     st_q, st_d;
    logic [CW-1:0] el_q, el_d;
    logic [CW-1:0] hit_q, hit_d;
    logic          differ;

    // In a rise window a tone sample counts; in a fall window a silent one does.
    assign differ = (st_q == PK_FALL_WIN) ? ~sample : sample;

    always_comb begin
        st_d  = st_q;
        el_d  = el_q;
        hit_d = hit_q;
        if (tick) begin
            unique case (st_q)
                PK_WAIT_OFF: begin
                    if (sample) begin
                        st_d  = PK_RISE_WIN;
                        el_d  = CW'(1);
                        hit_d = CW'(1);
                    end
                end
                PK_ON: begin
                    if (!sample) begin
                        st_d  = PK_FALL_WIN;
                        el_d  = CW'(1);
                        hit_d = CW'(1);
                    end
                end
                PK_RISE_WIN, PK_FALL_WIN: begin
                    el_d  = el_q + 1'b1;
                    hit_d = hit_q + CW'(differ);
                    if (hit_d == CW'(THRESH_MS)) begin
                        st_d  = (st_q == PK_RISE_WIN) ? PK_ON : PK_WAIT_OFF;
                        el_d  = '0;
                        hit_d = '0;
                    end else if (el_d == CW'(WIN_MS)) begin
                        st_d  = (st_q == PK_RISE_WIN) ? PK_WAIT_OFF : PK_ON;
                        el_d  = '0;
                        hit_d = '0;
                    end
                end
                default: st_d = PK_WAIT_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PK_WAIT_OFF;
            el_q  <= '0;
            hit_q <= '0;
        end else begin
            st_q  <= st_d;
            el_q  <= el_d;
            hit_q <= hit_d;
        end
    end

    always_comb begin
        level = (st_q == PK_ON) || (st_q == PK_FALL_WIN);
    end
endmodule

// File: rtl/metering_out_ctrl.sv
module metering_out_ctrl #(
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned TICK_BASE = 3579,
    parameter int unsigned WIN_MS    = 44,
    parameter int unsigned THRESH_MS = 32,
    parameter int unsigned TF_RUN_MS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tone_valid,
    input  logic              out_sel,
    input  logic              out_release,
    output logic [NUM_CH-1:0] ch_data,
    output logic [NUM_CH-1:0] ch_drive
);
    logic              ms_tick;
    logic [NUM_CH-1:0] tf_level;
    logic [NUM_CH-1:0] pk_level;

    ms_tick_gen #(.TICK_BASE(TICK_BASE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tone_follower #(.RUN_MS(TF_RUN_MS)) u_tf (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (ms_tick),
            .sample (tone_valid[c]),
            .level  (tf_level[c])
        );

        packet_integrator #(.WIN_MS(WIN_MS), .THRESH_MS(THRESH_MS)) u_pk (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (ms_tick),
            .sample (tone_valid[c]),
            .level  (pk_level[c])
        );
    end

    // Format multiplexer and pin release, shared by all channels.
    always_comb begin
        for (int c = 0; c < int'(NUM_CH); c++) begin
            ch_drive[c] = ~out_release;
            ch_data[c]  = out_release ? 1'b0 : (out_sel ? tf_level[c] : pk_level[c]);
        end
    end
endmodule

// File: rtl/metering_out_ctrl_chk.sv
module metering_out_ctrl_chk #(
    parameter int unsigned NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tone_valid,
    input logic              out_sel,
    input logic              out_release,
    input logic              ms_tick,
    input logic [NUM_CH-1:0] tf_level,
    input logic [NUM_CH-1:0] pk_level,
    input logic [NUM_CH-1:0] ch_data,
    input logic [NUM_CH-1:0] ch_drive
);
    p_release_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_release |-> (ch_drive == '0 && ch_data == '0));

    p_drive_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_release |-> (ch_drive == '1));

    p_sel_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_release && out_sel) |-> (ch_data == tf_level));

    p_sel_packet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_release && !out_sel) |-> (ch_data == pk_level));

    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |=> !ms_tick);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ms_tick |=> ($stable(tf_level[i]) && $stable(pk_level[i])));

        p_follow_rise_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tf_level[i]) |-> $past(tone_valid[i] && ms_tick));

        p_packet_rise_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pk_level[i]) |-> $past(tone_valid[i] && ms_tick));

        p_packet_fall_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pk_level[i]) |-> $past(!tone_valid[i] && ms_tick));
    end
endmodule

bind metering_out_ctrl metering_out_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tone_valid  (tone_valid),
    .out_sel     (out_sel),
    .out_release (out_release),
    .ms_tick     (ms_tick),
    .tf_level    (tf_level),
    .pk_level    (pk_level),
    .ch_data     (ch_data),
    .ch_drive    (ch_drive)
);

// File: tb/metering_out_ctrl_tb_top.sv
module metering_out_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 2;
    localparam int BASE = 3;
    localparam int WIN  = 44;
    localparam int THR  = 32;
    localparam int RUN  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] tone = '0;
    logic           sel = 1'b1;
    logic           rel = 1'b0;
    logic [NCH-1:0] data;
    logic [NCH-1:0] drive;

    always #(CLK_PERIOD / 2) clk = ~clk;

    metering_out_ctrl #(
        .NUM_CH(NCH), .TICK_BASE(BASE), .WIN_MS(WIN),
        .THRESH_MS(THR), .TF_RUN_MS(RUN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tone_valid(tone),
        .out_sel(sel), .out_release(rel),
        .ch_data(data), .ch_drive(drive)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_tag  = "";

    // Behavioural reference: millisecond schedule (R3) and per-channel decisions.
    int gap_left = BASE;
    int next_gap = BASE + 1;
    int tf_lvl [NCH];
    int tf_run [NCH];
    int pk_lvl [NCH];
    int pk_open[NCH];
    int pk_len [NCH];
    int pk_dis [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            gap_left = BASE;
            next_gap = BASE + 1;
            for (int c = 0; c < NCH; c++) begin
                tf_lvl[c] = 0; tf_run[c] = 0;
                pk_lvl[c] = 0; pk_open[c] = 0; pk_len[c] = 0; pk_dis[c] = 0;
            end
        end else begin
            gap_left = gap_left - 1;
            if (gap_left == 0) begin
                gap_left = next_gap;
                next_gap = (next_gap == BASE) ? BASE + 1 : BASE;
                for (int c = 0; c < NCH; c++) begin
                    int s;
                    s = int'(tone[c]);
                    if (s != tf_lvl[c]) begin
                        tf_run[c]++;
                        if (tf_run[c] == RUN) begin
                            tf_lvl[c] = s;
                            tf_run[c] = 0;
                        end
                    end else begin
                        tf_run[c] = 0;
                    end
                    if (pk_open[c] == 0) begin
                        if (s != pk_lvl[c]) begin
                            pk_open[c] = 1; pk_len[c] = 1; pk_dis[c] = 1;
                        end
                    end else begin
                        pk_len[c]++;
                        if (s != pk_lvl[c]) pk_dis[c]++;
                        if (pk_dis[c] == THR) begin
                            pk_lvl[c]  = 1 - pk_lvl[c];
                            pk_open[c] = 0;
                        end else if (pk_len[c] == WIN) begin
                            pk_open[c] = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        for (int c = 0; c < NCH; c++) begin
            int    exp_d;
            string tag;
            exp_d = rel ? 0 : (sel ? tf_lvl[c] : pk_lvl[c]);
            tag   = (cur_tag != "") ? cur_tag : (rel ? "R2" : (sel ? "R5" : "R6"));
            chk("R2", int'(drive[c]), rel ? 0 : 1);
            chk(tag, int'(data[c]), exp_d);
        end
    endtask

    function automatic logic pick(int m, int k);
        case (m)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return (k % 14) == 0;
            3:       return (k % 14) != 0;
            default: return 1'($urandom % 2);
        endcase
    endfunction

    task automatic seg(int n, int m0, int m1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cmp_all();
            tone[0] = pick(m0, k);
            tone[1] = pick(m1, k);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        tone = 2'b01; sel = 1'b1; rel = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", int'(data), 0);
        chk("R1", int'(drive), 3);
        rst_n = 1'b1;
        // R3: the fourth tick falls on edge BASE+(BASE+1)+BASE+(BASE+1) = 14.
        repeat (13) begin @(negedge clk); cmp_all(); end
        chk("R3", int'(data[0]), 0);
        @(negedge clk); cmp_all();
        chk("R3", int'(data[0]), 1);
        chk("R9", int'(data[1]), 0);

        // Tone follower format (R5)
        seg(60, 1, 0);
        seg(5, 0, 0);
        @(negedge clk); cmp_all();
        chk("R5", int'(data[0]), 1);
        seg(40, 0, 1);
        @(negedge clk); cmp_all();
        chk("R5", int'(data[0]), 0);
        chk("R9", int'(data[1]), 1);

        // Output release (R2)
        @(negedge clk); cmp_all();
        rel = 1'b1; #1;
        chk("R2", int'(drive), 0);
        chk("R2", int'(data), 0);
        seg(20, 1, 0);
        @(negedge clk);
        rel = 1'b0; #1;
        chk("R2", int'(drive), 3);

        // Switch to packet format in the same cycle (R4)
        @(negedge clk); cmp_all();
        sel = 1'b0; #1;
        chk("R4", int'(data[0]), pk_lvl[0]);
        chk("R4", int'(data[1]), pk_lvl[1]);

        // Packet respond (R6), partial and full de-respond (R8)
        seg(200, 1, 0);
        @(negedge clk); cmp_all();
        chk("R6", int'(data[0]), 1);
        chk("R9", int'(data[1]), 0);
        seg(60, 0, 0);
        @(negedge clk); cmp_all();
        chk("R8", int'(data[0]), 1);
        seg(100, 0, 0);
        @(negedge clk); cmp_all();
        chk("R8", int'(data[0]), 0);

        // Sparse tone never reaches the count: windows expire (R7)
        seg(700, 2, 2);
        @(negedge clk); cmp_all();
        chk("R7", int'(data[0]), 0);
        chk("R7", int'(data[1]), 0);
        seg(200, 0, 1);
        @(negedge clk); cmp_all();
        chk("R6", int'(data[1]), 1);
        seg(700, 0, 3);
        @(negedge clk); cmp_all();
        chk("R7", int'(data[1]), 1);

        // Follower level still tracked while packet was selected (R4)
        @(negedge clk); cmp_all();
        sel = 1'b1; #1;
        chk("R4", int'(data[0]), 0);
        chk("R4", int'(data[1]), 1);

        // Input toggling on arbitrary cycles, both formats (R10)
        cur_tag = "R10";
        seg(800, 4, 4);
        sel = 1'b0;
        seg(800, 4, 4);
        cur_tag = "";
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual still running, expected finished");
            report();
        end
    end
endmodule